// File: doc/BRIEF.md
# Keyboard Wake-Up Interrupt Controller

This block watches four keyboard input pins and raises one interrupt request toward the CPU when a key is pressed. Each pin can be enabled as an interrupt source. Each pin also has its own pull-up enable, which is independent of the interrupt enable. The pins are first synchronised to the block clock. They are then merged into one "all enabled pins high" signal. A request is latched on the transition of that merged signal from high to low.

A mode bit selects between two trigger modes:

- **Edge-only mode.** An acknowledge clears the request at once.
- **Edge-plus-level mode.** The request stays set while any enabled pin is low. It clears only after both of these have happened, in either order:
  - an acknowledge has arrived;
  - all enabled pins have returned high.

An acknowledge comes from either of two sources: a vector-fetch strobe from the CPU, or software writing a one to a self-clearing bit. A mask bit gates the interrupt output. The pending flag stays readable whatever the mask says.

The block also produces the effective pin direction. A pin enabled as an interrupt source is forced to be an input. It also produces the pull-up enables for the pad logic. There are two registers, selected by one address bit:

- **Enable register** (address 0): bits 3:0 are the per-pin interrupt enables; bits 7:4 are the per-pin pull-up enables.
- **Control register** (address 1): bit 0 is the mode (1 = edge plus level), bit 1 is the mask, bit 2 is the write-one acknowledge, bit 3 is the pending flag, and bits 7:4 read as zero.

Top module: `kbd_irq_ctrl`

## Requirements
- R1: Output pullup_en equals enable-register bits 7:4, and pin n's pull-up follows bit 4+n alone; setting interrupt enable bit n (bit n) never turns the pull-up on.
- R2: For every pin n, dir_eff[n] is 0 (input) whenever interrupt enable bit n is set, and equals ddr_in[n] (1 = output) otherwise.
- R3: The request latches only when the combined signal (every enabled pin high, disabled pins ignored) falls from 1 to 0; a pin change driven before a rising edge shows as pending (control bit 3) after the third rising edge, not the second.
- R4: In edge-only mode (control bit 0 = 0), a falling pin while another enabled pin is already low latches nothing, and a disabled pin never latches a request.
- R5: In edge-only mode, an acknowledge (vec_ack high, or a write to address 1 with data bit 2 set) clears the request at the next rising edge even while pins stay low.
- R6: In edge-plus-level mode (control bit 0 = 1), the request stays set while any enabled pin is low and clears once an acknowledge has been seen and all enabled pins are high, in either order.
- R7: Control bit 2 always reads 0, writes to bit 3 have no effect on the pending flag, and a qualifying falling edge after an acknowledge latches a new request.
- R8: When an acknowledge and a new qualifying falling edge fall in the same cycle, the request stays set.
- R9: irq_out is high exactly when pending is set and the mask (control bit 1) is 0; the pending flag ignores the mask.
- R10: Reset clears the request, mode, mask and both enable fields, and no request appears after reset even if a pin is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 4 | Raw keyboard pin levels |
| ddr_in | input | 4 | Port direction setting per pin, 1 = output |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 enable, 1 control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| vec_ack | input | 1 | Interrupt vector-fetch acknowledge strobe |
| irq_out | output | 1 | Interrupt request to the CPU |
| dir_eff | output | 4 | Effective pin direction, 1 = output |
| pullup_en | output | 4 | Pull-up enable per pin |

## Verification
The hardest case is an acknowledge that arrives in the very cycle a new qualifying fall reaches the request logic. Producing it means counting the two synchroniser stages: a new pin is dropped, two edges later the fall is visible, and the vector-fetch strobe is pulsed exactly then. The two clearing orders of level mode are also driven on purpose: acknowledge first with keys held, and keys released first with the acknowledge late. A behavioural reference model runs beside the design and checks all outputs every cycle.

// File: rtl/kbd_irq_pkg.sv
package kbd_irq_pkg;
  localparam int unsigned NPINS   = 4;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned SYNC_STAGES = 2;

  // control register bit positions
  localparam int unsigned CTL_MODE = 0;
  localparam int unsigned CTL_MASK = 1;
  localparam int unsigned CTL_ACK  = 2;
  localparam int unsigned CTL_PEND = 3;

  localparam logic ADDR_ENABLE = 1'b0;
  localparam logic ADDR_CTRL   = 1'b1;

  typedef enum logic {
    TRIG_EDGE       = 1'b0,
    TRIG_EDGE_LEVEL = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/kbd_pin_sync.sv
module kbd_pin_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  // Each pin gets its own chain; idle level of a keyboard line is high.
  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], d_in[p]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '1;
      end else begin
        chain_q <= chain_d;
      end
    end

    assign q_out[p] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/kbd_combine.sv
module kbd_combine #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_sync,
  input  logic [WIDTH-1:0] irq_en,
  output logic             all_high,
  output logic             fall
);
  logic [WIDTH-1:0] qualified;
  logic             prev_q;
  logic             prev_d;

  // A disabled pin counts as high so it can never pull the group low.
  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      qualified[i] = pin_sync[i] | ~irq_en[i];
    end
    all_high = &qualified;
    fall     = prev_q & ~all_high;
    prev_d   = all_high;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
    end else begin
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/kbd_req_latch.sv
module kbd_req_latch
  import kbd_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fall,
  input  logic       all_high,
  input  logic       ack,
  input  trig_mode_e mode,
  output logic       req
);
  logic req_q, req_d;
  logic ack_seen_q, ack_seen_d;
  logic ack_any;

  always_comb begin
    ack_any    = ack | ack_seen_q;
    req_d      = req_q;
    ack_seen_d = ack_seen_q;

    if (fall) begin
      // a fresh qualifying edge always wins over a coincident acknowledge
      req_d      = 1'b1;
      ack_seen_d = 1'b0;
    end else if (req_q) begin
      unique case (mode)
        TRIG_EDGE: begin
          if (ack) begin
            req_d = 1'b0;
          end
          ack_seen_d = 1'b0;
        end
        TRIG_EDGE_LEVEL: begin
          if (ack_any && all_high) begin
            req_d      = 1'b0;
            ack_seen_d = 1'b0;
          end else if (ack) begin
            ack_seen_d = 1'b1;
          end
        end
        default: begin
          req_d = req_q;
        end
      endcase
    end else begin
      ack_seen_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q      <= 1'b0;
      ack_seen_q <= 1'b0;
    end else begin
      req_q      <= req_d;
      ack_seen_q <= ack_seen_d;
    end
  end

  assign req = req_q;
endmodule

// File: rtl/kbd_regs.sv
module kbd_regs
  import kbd_irq_pkg::*;
#(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             addr,
  input  logic [DW-1:0]    wdata,
  input  logic             pending,
  output logic [DW-1:0]    rdata,
  output logic [WIDTH-1:0] irq_en,
  output logic [WIDTH-1:0] pu_en,
  output trig_mode_e       mode,
  output logic             mask,
  output logic             sw_ack
);
  logic [WIDTH-1:0] irq_en_q, irq_en_d;
  logic [WIDTH-1:0] pu_en_q, pu_en_d;
  logic             mode_q, mode_d;
  logic             mask_q, mask_d;
  logic             en_we, ctl_we;

  always_comb begin
    en_we    = wr && (addr == ADDR_ENABLE);
    ctl_we   = wr && (addr == ADDR_CTRL);
    irq_en_d = en_we  ? wdata[WIDTH-1:0]       : irq_en_q;
    pu_en_d  = en_we  ? wdata[2*WIDTH-1:WIDTH] : pu_en_q;
    mode_d   = ctl_we ? wdata[CTL_MODE]        : mode_q;
    mask_d   = ctl_we ? wdata[CTL_MASK]        : mask_q;
    sw_ack   = ctl_we && wdata[CTL_ACK];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q <= '0;
      pu_en_q  <= '0;
      mode_q   <= 1'b0;
      mask_q   <= 1'b0;
    end else begin
      irq_en_q <= irq_en_d;
      pu_en_q  <= pu_en_d;
      mode_q   <= mode_d;
      mask_q   <= mask_d;
    end
  end

  // read mux; acknowledge bit is write-only and reads back zero
  always_comb begin
    rdata = '0;
    if (addr == ADDR_ENABLE) begin
      rdata[WIDTH-1:0]       = irq_en_q;
      rdata[2*WIDTH-1:WIDTH] = pu_en_q;
    end else begin
      rdata[CTL_MODE] = mode_q;
      rdata[CTL_MASK] = mask_q;
      rdata[CTL_PEND] = pending;
    end
  end

  assign irq_en = irq_en_q;
  assign pu_en  = pu_en_q;
  assign mode   = trig_mode_e'(mode_q);
  assign mask   = mask_q;
endmodule

// File: rtl/kbd_irq_ctrl.sv
module kbd_irq_ctrl
  import kbd_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_in,
  input  logic [NPINS-1:0]  ddr_in,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              vec_ack,
  output logic              irq_out,
  output logic [NPINS-1:0]  dir_eff,
  output logic [NPINS-1:0]  pullup_en
);
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] irq_en;
  logic [NPINS-1:0] pu_en;
  trig_mode_e       mode;
  logic             mask;
  logic             sw_ack;
  logic             ack;
  logic             all_high;
  logic             fall;
  logic             req;

  kbd_pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pin_in),
    .q_out (pin_sync)
  );

  kbd_combine #(.WIDTH(NPINS)) u_comb (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_sync (pin_sync),
    .irq_en   (irq_en),
    .all_high (all_high),
    .fall     (fall)
  );

  kbd_regs #(.WIDTH(NPINS), .DW(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .pending (req),
    .rdata   (reg_rdata),
    .irq_en  (irq_en),
    .pu_en   (pu_en),
    .mode    (mode),
    .mask    (mask),
    .sw_ack  (sw_ack)
  );

  assign ack = vec_ack | sw_ack;

  kbd_req_latch u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall     (fall),
    .all_high (all_high),
    .ack      (ack),
    .mode     (mode),
    .req      (req)
  );

  // an interrupt-enabled pin is always an input
  for (genvar p = 0; p < NPINS; p++) begin : g_dir
    assign dir_eff[p] = ddr_in[p] & ~irq_en[p];
  end

  assign pullup_en = pu_en;
  assign irq_out   = req & ~mask;
endmodule

// File: rtl/kbd_irq_ctrl_chk.sv
module kbd_irq_ctrl_chk
  import kbd_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             fall,
  input logic             all_high,
  input logic             ack,
  input logic             req,
  input trig_mode_e       mode,
  input logic             mask,
  input logic             irq_out,
  input logic [NPINS-1:0] irq_en,
  input logic [NPINS-1:0] dir_eff,
  input logic             reg_addr,
  input logic [DATA_W-1:0] reg_rdata
);
  assert_fall_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> req);

  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && !fall) |=> !req);

  assert_edge_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !fall && ack && mode == TRIG_EDGE) |=> !req);

  assert_level_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !all_high && mode == TRIG_EDGE_LEVEL) |=> req);

  assert_tie_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && ack) |=> req);

  assert_mask_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (req && !mask));

  assert_unmasked_fires_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !mask) |-> irq_out);

  assert_enabled_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en & dir_eff) == '0);

  assert_ack_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_CTRL) |-> !reg_rdata[CTL_ACK]);
endmodule

bind kbd_irq_ctrl kbd_irq_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fall      (fall),
  .all_high  (all_high),
  .ack       (ack),
  .req       (req),
  .mode      (mode),
  .mask      (mask),
  .irq_out   (irq_out),
  .irq_en    (irq_en),
  .dir_eff   (dir_eff),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata)
);

// File: tb/kbd_irq_ctrl_tb.sv
`timescale 1ns/1ps
module kbd_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] pin_in;
  logic [3:0] ddr_in;
  logic       reg_wr;
  logic       reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       vec_ack;
  logic       irq_out;
  logic [3:0] dir_eff;
  logic [3:0] pullup_en;

  int total = 0;
  int bad   = 0;
  bit model_live = 1'b0;

  always #4 clk = ~clk;

  kbd_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .ddr_in(ddr_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .vec_ack(vec_ack), .irq_out(irq_out),
    .dir_eff(dir_eff), .pullup_en(pullup_en)
  );

  task automatic check(input string req_tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req_tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [3:0] pins_d1, pins_d2;     // pin history, two cycles deep
  bit       was_high;
  bit       m_pend, m_acked;
  bit [3:0] m_ie, m_pe;
  bit       m_mode, m_mask;

  always @(posedge clk) begin
    bit grp_high, drop, any_ack;
    if (!rst_n) begin
      pins_d1 = 4'hF; pins_d2 = 4'hF; was_high = 1'b1;
      m_pend = 0; m_acked = 0; m_ie = 0; m_pe = 0; m_mode = 0; m_mask = 0;
      model_live = 1'b1;
    end else begin
      grp_high = 1'b1;
      for (int i = 0; i < 4; i++)
        if (m_ie[i] && !pins_d2[i]) grp_high = 1'b0;
      drop    = was_high && !grp_high;
      any_ack = vec_ack || (reg_wr && reg_addr && reg_wdata[2]);
      if (drop) begin
        m_pend = 1; m_acked = 0;
      end else if (m_pend) begin
        if (!m_mode) begin
          if (any_ack) m_pend = 0;
          m_acked = 0;
        end else if ((any_ack || m_acked) && grp_high) begin
          m_pend = 0; m_acked = 0;
        end else if (any_ack) begin
          m_acked = 1;
        end
      end
      if (reg_wr && !reg_addr) begin m_ie = reg_wdata[3:0]; m_pe = reg_wdata[7:4]; end
      if (reg_wr && reg_addr)  begin m_mode = reg_wdata[0]; m_mask = reg_wdata[1]; end
      was_high = grp_high;
      pins_d2  = pins_d1;
      pins_d1  = pin_in;
    end
    #2;
    if (model_live) begin
      check("R9 irq_out", irq_out, int'(m_pend && !m_mask));
      check("R1 pullup_en", pullup_en, m_pe);
      check("R2 dir_eff", dir_eff, ddr_in & ~m_ie);
      if (reg_addr) check("R7 ctrl read", reg_rdata, {4'b0, m_pend, 1'b0, m_mask, m_mode});
      else          check("R1 enable read", reg_rdata, {m_pe, m_ie});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_addr = 1'b1; reg_wdata = 8'h00;
  endtask

  task automatic pulse_ack();
    vec_ack = 1'b1; tick(); vec_ack = 1'b0;
  endtask

  function automatic int pend();
    return int'(reg_rdata[3]);
  endfunction

  initial begin : watchdog
    #(8 * 20000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin_in = 4'hF; ddr_in = 4'hF; reg_wr = 0;
    reg_addr = 1'b1; reg_wdata = 0; vec_ack = 0;
    tick(3);
    rst_n = 1'b1;
    tick();
    // R10: reset state
    check("R10 ctrl after reset", reg_rdata, 0);
    check("R10 irq after reset", irq_out, 0);

    // R1 / R2: pull-up and direction overrides
    wr(0, 8'h50);
    check("R1 pullup only from bits 7:4", pullup_en, 4'h5);
    check("R2 no enable keeps ddr", dir_eff, 4'hF);
    wr(0, 8'h03);
    check("R1 irq enable leaves pull-up off", pullup_en, 4'h0);
    check("R2 enabled pins forced input", dir_eff, 4'hC);

    // R3: single pin falls, edge mode, unmasked
    wr(0, 8'h0F); wr(1, 8'h00);
    pin_in = 4'hE;
    tick(2);
    check("R3 not yet after two edges", pend(), 0);
    tick();
    check("R3 pending on third edge", pend(), 1);
    check("R9 irq unmasked", irq_out, 1);

    // R5: ack clears with pin still low
    pulse_ack();
    check("R5 vector ack clears", pend(), 0);
    // R4: second pin falls while first low
    pin_in = 4'hC; tick(5);
    check("R4 blocked by low pin", pend(), 0);
    pin_in = 4'hF; tick(4);

    // R4: disabled pin ignored
    wr(0, 8'h07);
    pin_in = 4'h7; tick(5);
    check("R4 disabled pin ignored", pend(), 0);
    pin_in = 4'hF; tick(4);
    wr(0, 8'h0F);

    // R7: software ack, bit read, pending write, new edge after ack
    pin_in = 4'hB; tick(3);
    check("R7 pending set", pend(), 1);
    wr(1, 8'h04);
    check("R5 software ack clears", pend(), 0);
    check("R7 ack bit reads zero", reg_rdata[2], 0);
    wr(1, 8'h08);
    check("R7 pending write ignored", pend(), 0);
    pin_in = 4'hF; tick(3);
    pin_in = 4'hB; tick(3);
    check("R7 edge after ack relatches", pend(), 1);

    // R9: mask hides output only
    wr(1, 8'h02);
    check("R9 masked irq low", irq_out, 0);
    check("R9 pending survives mask", pend(), 1);
    wr(1, 8'h04);
    pin_in = 4'hF; tick(4);

    // R8: ack coincides with a new qualifying fall
    pin_in = 4'hD; tick(3);
    pin_in = 4'hF; tick(4);
    check("R8 edge-mode request held", pend(), 1);
    pin_in = 4'hB; tick(2);
    pulse_ack();
    check("R8 new edge beats ack", pend(), 1);
    pulse_ack();
    pin_in = 4'hF; tick(4);

    // R6: level mode, ack first then release
    wr(1, 8'h01);
    pin_in = 4'h7; tick(3);
    check("R6 level pending", pend(), 1);
    pulse_ack(); tick(2);
    check("R6 held while low after ack", pend(), 1);
    pin_in = 4'hF; tick(2);
    check("R6 still set before sync", pend(), 1);
    tick();
    check("R6 clears after ack then release", pend(), 0);

    // R6: release first then ack
    pin_in = 4'hE; tick(3);
    pin_in = 4'hF; tick(5);
    check("R6 held without ack", pend(), 1);
    pulse_ack();
    check("R6 clears on late ack", pend(), 0);

    // R10: reset with pin held low
    pin_in = 4'hE; tick(3);
    check("R10 pending before reset", pend(), 1);
    rst_n = 1'b0; tick(2);
    rst_n = 1'b1; tick(4);
    check("R10 cleared with pin low", pend(), 0);
    check("R10 mode cleared", reg_rdata[0], 0);
    reg_addr = 1'b0; tick();
    check("R10 enables cleared", reg_rdata, 0);

    tick(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule